// File: doc/BRIEF.md
# Multilinear Sumcheck Folding Engine

This block carries out the prover half of a multilinear sumcheck over a prime field. Software or a neighbouring block first writes a table of 2^n field elements into the engine's internal storage. The table holds the evaluations of a multilinear polynomial over the boolean hypercube, with any unused tail positions set to zero. A start pulse then launches the first round. In each round the engine walks the active table one adjacent pair per cycle. It sums the even-indexed entries to give the round polynomial's value at 0, and the odd-indexed entries to give its value at 1.

The two sums, tagged with the round number, are offered on a valid/ready output. Once they are taken, the engine waits for a challenge on a separate valid/ready input. It then folds every pair (a, b) into a + c·(b − a) mod P, with one field multiply per pair. Result i is written back in place at index i, which halves the table for the next round. No round begins until the challenge of the round before it has been consumed.

After the n-th challenge the single remaining element is the polynomial's value at the full challenge point. It is presented on a result port, and a done flag is raised.

Top module: `sumcheck_fold_engine`

## Requirements
- R1: While reset is asserted, and after it is released, round_valid, chal_ready and done are all 0.
- R2: Round k (numbered 1 to n, reported on round_idx) offers eval_zero = sum of the entries at even indices of the active table mod P and eval_one = sum of the entries at odd indices mod P. The active table for round 1 is the loaded 2^n entries at addresses 0 to 2^n − 1.
- R3: After challenge c is accepted, entry i of the next table equals t[2i] + c·(t[2i+1] − t[2i]) mod P, for i from 0 to half the current length minus 1. The following round's sums are formed from that table.
- R4: Strict barrier. The round output stays valid with stable contents until round_ready is seen. chal_ready is 1 only after the round output has been accepted and is never 1 together with round_valid. A challenge offered earlier is not consumed.
- R5: Exactly n rounds are offered. After the n-th challenge is consumed, done is 1, final_value equals the fully folded value, and round_valid and chal_ready stay 0.
- R6: With h the pair count of a round, round_valid appears h+1 cycles after the start edge, counting that edge. After a challenge edge, the next round's output appears 1 + h + h/2 cycles later, counting that edge. done appears 2 cycles after the final challenge edge, counting that edge.
- R7: While a run is in progress (from the start edge until done), writes on the load port and further start pulses are ignored. Loads and start are accepted when idle or done.
- R8: Every value shown on eval_zero, eval_one and final_value is below P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write one table entry this cycle |
| load_addr | input | LOG_N | Table index to write |
| load_data | input | WIDTH | Field element to write (must be below P) |
| start | input | 1 | Begin round 1 on the loaded table |
| round_valid | output | 1 | Round evaluations are on offer |
| round_ready | input | 1 | Consumer takes the round evaluations |
| round_idx | output | clog2(LOG_N+1) | Round number, 1 to LOG_N |
| eval_zero | output | WIDTH | Round polynomial at X = 0 |
| eval_one | output | WIDTH | Round polynomial at X = 1 |
| chal_valid | input | 1 | A challenge is offered |
| chal_ready | output | 1 | Engine is waiting for the challenge |
| chal_value | input | WIDTH | Challenge field element (below P) |
| done | output | 1 | All rounds folded |
| final_value | output | WIDTH | Table value at the full challenge point |

## Verification
Every result has a fixed distance from the stimulus that triggers it. The round sums follow the start edge after h+1 rising edges. After a challenge edge, a fold of h pairs and a scan of h/2 pairs run before the next sums appear. done follows the final challenge edge by one fold cycle. The bench counts rising edges from the triggering handshake up to the negative edge where round_valid or done is first seen, and compares that count with the formula. All data values are read at the same negative edge and compared with a software model of the even/odd sums and the in-place fold. Barrier and ignore checks hold the output stalled for a cycle and confirm that the offered contents and chal_ready have not moved.

// File: rtl/sc_fold_pkg.sv
package sc_fold_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SCAN  = 3'd1,
      ST_OFFER = 3'd2,
      ST_CHAL  = 3'd3,
      ST_FOLD  = 3'd4,
      ST_DONE  = 3'd5
   } fold_state_t;

endpackage

// File: rtl/sc_mod_addsub.sv
module sc_mod_addsub #(
   parameter int          WIDTH    = 16,
   parameter int unsigned PRIME    = 65521,
   parameter bit          SUBTRACT = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);
   localparam logic [WIDTH:0] P_EXT = (WIDTH+1)'(PRIME);

   logic [WIDTH:0] a_ext;
   logic [WIDTH:0] b_ext;

   assign a_ext = {1'b0, a};
   assign b_ext = {1'b0, b};

   generate
      if (SUBTRACT) begin : g_sub
         logic [WIDTH:0] wrap;
         assign wrap = a_ext + P_EXT - b_ext;
         always_comb begin
            if (a_ext >= b_ext) y = WIDTH'(a_ext - b_ext);
            else                y = WIDTH'(wrap);
         end
      end else begin : g_add
         logic [WIDTH:0] sum;
         assign sum = a_ext + b_ext;
         always_comb begin
            if (sum >= P_EXT) y = WIDTH'(sum - P_EXT);
            else              y = WIDTH'(sum);
         end
      end
   endgenerate
endmodule

// File: rtl/sc_mod_mul.sv
module sc_mod_mul #(
   parameter int          WIDTH = 16,
   parameter int unsigned PRIME = 65521
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);
   localparam int          PW    = 2 * WIDTH;
   localparam logic [PW-1:0] P_WIDE = PW'(PRIME);

   logic [PW-1:0] prod;

   assign prod = PW'(a) * PW'(b);
   assign y    = WIDTH'(prod % P_WIDE);
endmodule

// File: rtl/sc_vec_ram.sv
module sc_vec_ram #(
   parameter int WIDTH = 16,
   parameter int LOG_N = 3
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [LOG_N-1:0] wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [LOG_N-1:0] rd_addr_even,
   input  logic [LOG_N-1:0] rd_addr_odd,
   output logic [WIDTH-1:0] rd_even,
   output logic [WIDTH-1:0] rd_odd
);
   localparam int DEPTH = 1 << LOG_N;

   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign rd_even = cells[rd_addr_even];
   assign rd_odd  = cells[rd_addr_odd];
endmodule

// File: rtl/sc_fold_lane.sv
module sc_fold_lane #(
   parameter int          WIDTH = 16,
   parameter int unsigned PRIME = 65521
) (
   input  logic [WIDTH-1:0] lo,
   input  logic [WIDTH-1:0] hi,
   input  logic [WIDTH-1:0] coeff,
   input  logic [WIDTH-1:0] sum_lo,
   input  logic [WIDTH-1:0] sum_hi,
   output logic [WIDTH-1:0] sum_lo_nxt,
   output logic [WIDTH-1:0] sum_hi_nxt,
   output logic [WIDTH-1:0] folded
);
   logic [WIDTH-1:0] delta;
   logic [WIDTH-1:0] scaled;

   // running sums for the round polynomial
   sc_mod_addsub #(.WIDTH(WIDTH), .PRIME(PRIME), .SUBTRACT(1'b0)) u_acc_lo (
      .a(sum_lo), .b(lo), .y(sum_lo_nxt));
   sc_mod_addsub #(.WIDTH(WIDTH), .PRIME(PRIME), .SUBTRACT(1'b0)) u_acc_hi (
      .a(sum_hi), .b(hi), .y(sum_hi_nxt));

   // lo + coeff*(hi - lo): a single field multiply per pair
   sc_mod_addsub #(.WIDTH(WIDTH), .PRIME(PRIME), .SUBTRACT(1'b1)) u_delta (
      .a(hi), .b(lo), .y(delta));
   sc_mod_mul #(.WIDTH(WIDTH), .PRIME(PRIME)) u_scale (
      .a(coeff), .b(delta), .y(scaled));
   sc_mod_addsub #(.WIDTH(WIDTH), .PRIME(PRIME), .SUBTRACT(1'b0)) u_join (
      .a(lo), .b(scaled), .y(folded));
endmodule

// File: rtl/sumcheck_fold_engine.sv
module sumcheck_fold_engine #(
   parameter int          WIDTH = 16,
   parameter int unsigned PRIME = 65521,
   parameter int          LOG_N = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_en,
   input  logic [LOG_N-1:0]               load_addr,
   input  logic [WIDTH-1:0]               load_data,
   input  logic                           start,
   output logic                           round_valid,
   input  logic                           round_ready,
   output logic [$clog2(LOG_N+1)-1:0]     round_idx,
   output logic [WIDTH-1:0]               eval_zero,
   output logic [WIDTH-1:0]               eval_one,
   input  logic                           chal_valid,
   output logic                           chal_ready,
   input  logic [WIDTH-1:0]               chal_value,
   output logic                           done,
   output logic [WIDTH-1:0]               final_value
);
   import sc_fold_pkg::*;

   localparam int              RW        = $clog2(LOG_N + 1);
   localparam logic [LOG_N-1:0] HALF_INIT = LOG_N'(1 << (LOG_N - 1));
   localparam logic [RW-1:0]   LAST_RND  = RW'(LOG_N);

   // elaboration-time parameter checks
   generate
      if (LOG_N < 1) begin : g_bad_log
         $error("LOG_N must be at least 1");
      end
      if (PRIME < 2) begin : g_bad_prime
         $error("PRIME must be at least 2");
      end
      if ((64'(PRIME) >> WIDTH) != 64'd0) begin : g_bad_width
         $error("PRIME must fit below 2**WIDTH");
      end
   endgenerate

   fold_state_t        state;
   logic [LOG_N-1:0]   pc;
   logic [LOG_N-1:0]   half;
   logic [RW-1:0]      round;
   logic [WIDTH-1:0]   acc_lo;
   logic [WIDTH-1:0]   acc_hi;
   logic [WIDTH-1:0]   alpha;
   logic [WIDTH-1:0]   result;

   logic               busy;
   logic               last_pair;
   logic               last_round;
   logic [LOG_N-1:0]   addr_even;
   logic [LOG_N-1:0]   addr_odd;
   logic [WIDTH-1:0]   val_even;
   logic [WIDTH-1:0]   val_odd;
   logic [WIDTH-1:0]   acc_lo_nxt;
   logic [WIDTH-1:0]   acc_hi_nxt;
   logic [WIDTH-1:0]   fold_val;
   logic               ram_we;
   logic [LOG_N-1:0]   ram_waddr;
   logic [WIDTH-1:0]   ram_wdata;

   assign busy       = (state != ST_IDLE) && (state != ST_DONE);
   assign last_pair  = (pc == half - LOG_N'(1));
   assign last_round = (round == LAST_RND);
   assign addr_even  = LOG_N'({pc, 1'b0});
   assign addr_odd   = addr_even | LOG_N'(1);

   // write port: loader when quiet, folder while folding
   always_comb begin
      if (state == ST_FOLD) begin
         ram_we    = 1'b1;
         ram_waddr = pc;
         ram_wdata = fold_val;
      end else begin
         ram_we    = load_en && !busy;
         ram_waddr = load_addr;
         ram_wdata = load_data;
      end
   end

   sc_vec_ram #(.WIDTH(WIDTH), .LOG_N(LOG_N)) u_ram (
      .clk          (clk),
      .wr_en        (ram_we),
      .wr_addr      (ram_waddr),
      .wr_data      (ram_wdata),
      .rd_addr_even (addr_even),
      .rd_addr_odd  (addr_odd),
      .rd_even      (val_even),
      .rd_odd       (val_odd)
   );

   sc_fold_lane #(.WIDTH(WIDTH), .PRIME(PRIME)) u_lane (
      .lo         (val_even),
      .hi         (val_odd),
      .coeff      (alpha),
      .sum_lo     (acc_lo),
      .sum_hi     (acc_hi),
      .sum_lo_nxt (acc_lo_nxt),
      .sum_hi_nxt (acc_hi_nxt),
      .folded     (fold_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pc     <= '0;
         half   <= HALF_INIT;
         round  <= '0;
         acc_lo <= '0;
         acc_hi <= '0;
         alpha  <= '0;
         result <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state  <= ST_SCAN;
                  pc     <= '0;
                  half   <= HALF_INIT;
                  round  <= RW'(1);
                  acc_lo <= '0;
                  acc_hi <= '0;
               end
            end
            ST_SCAN: begin
               acc_lo <= acc_lo_nxt;
               acc_hi <= acc_hi_nxt;
               if (last_pair) begin
                  pc    <= '0;
                  state <= ST_OFFER;
               end else begin
                  pc <= pc + LOG_N'(1);
               end
            end
            ST_OFFER: begin
               if (round_ready) state <= ST_CHAL;
            end
            ST_CHAL: begin
               if (chal_valid) begin
                  alpha <= chal_value;
                  state <= ST_FOLD;
               end
            end
            ST_FOLD: begin
               if (last_pair) begin
                  pc <= '0;
                  if (last_round) begin
                     result <= fold_val;
                     state  <= ST_DONE;
                  end else begin
                     round  <= round + RW'(1);
                     half   <= half >> 1;
                     acc_lo <= '0;
                     acc_hi <= '0;
                     state  <= ST_SCAN;
                  end
               end else begin
                  pc <= pc + LOG_N'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign round_valid = (state == ST_OFFER);
   assign chal_ready  = (state == ST_CHAL);
   assign done        = (state == ST_DONE);
   assign round_idx   = round;
   assign eval_zero   = acc_lo;
   assign eval_one    = acc_hi;
   assign final_value = result;
endmodule

// File: rtl/sc_fold_checker.sv
module sc_fold_checker #(
   parameter int          WIDTH = 16,
   parameter int unsigned PRIME = 65521,
   parameter int          LOG_N = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       round_valid,
   input logic                       round_ready,
   input logic [$clog2(LOG_N+1)-1:0] round_idx,
   input logic [WIDTH-1:0]           eval_zero,
   input logic [WIDTH-1:0]           eval_one,
   input logic                       chal_ready,
   input logic                       done,
   input logic [WIDTH-1:0]           final_value
);
   localparam logic [WIDTH:0] P_EXT = (WIDTH+1)'(PRIME);

   // R4: a stalled offer keeps its contents
   assert_offer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (round_valid && !round_ready) |=>
         (round_valid && $stable(eval_zero) && $stable(eval_one) && $stable(round_idx)));

   // R4: offer and challenge wait never overlap
   assert_barrier_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(round_valid && chal_ready));

   // R2: reported round number stays within 1..n
   assert_round_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      round_valid |-> (round_idx >= 1 && 32'(round_idx) <= LOG_N));

   // R5: finished engine offers nothing more
   assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!round_valid && !chal_ready));

   // R8: offered evaluations are reduced
   assert_eval_in_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
      round_valid |-> ({1'b0, eval_zero} < P_EXT && {1'b0, eval_one} < P_EXT));

   // R8: final value is reduced
   assert_final_in_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ({1'b0, final_value} < P_EXT));
endmodule

bind sumcheck_fold_engine sc_fold_checker #(
   .WIDTH(WIDTH), .PRIME(PRIME), .LOG_N(LOG_N)
) u_fold_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .round_valid (round_valid),
   .round_ready (round_ready),
   .round_idx   (round_idx),
   .eval_zero   (eval_zero),
   .eval_one    (eval_one),
   .chal_ready  (chal_ready),
   .done        (done),
   .final_value (final_value)
);

// File: tb/test_sumcheck_fold_engine.sv
module test_sumcheck_fold_engine;
   localparam int          WIDTH = 16;
   localparam int unsigned PRIME = 65521;
   localparam int          LOG_N = 3;
   localparam int          DEPTH = 1 << LOG_N;
   localparam int          NCASE = 4;
   localparam longint      P     = longint'(PRIME);

   // stimulus table: loaded vector and the three challenges per case
   localparam int unsigned VEC [NCASE][DEPTH] = '{
      '{1, 2, 3, 4, 5, 6, 7, 8},
      '{65520, 65520, 65520, 65520, 65520, 65520, 65520, 65520},
      '{100, 200, 0, 0, 0, 0, 0, 0},
      '{40000, 50000, 60000, 1, 65000, 12, 33333, 44444}
   };
   localparam int unsigned CHL [NCASE][LOG_N] = '{
      '{2, 3, 5},
      '{65520, 1, 0},
      '{1, 0, 0},
      '{60000, 7, 65000}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             load_en = 1'b0;
   logic [LOG_N-1:0] load_addr = '0;
   logic [WIDTH-1:0] load_data = '0;
   logic             start = 1'b0;
   logic             round_valid;
   logic             round_ready = 1'b0;
   logic [1:0]       round_idx;
   logic [WIDTH-1:0] eval_zero;
   logic [WIDTH-1:0] eval_one;
   logic             chal_valid = 1'b0;
   logic             chal_ready;
   logic [WIDTH-1:0] chal_value = '0;
   logic             done;
   logic [WIDTH-1:0] final_value;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sumcheck_fold_engine #(.WIDTH(WIDTH), .PRIME(PRIME), .LOG_N(LOG_N)) i_sumcheck_fold_engine (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
      .start(start),
      .round_valid(round_valid), .round_ready(round_ready), .round_idx(round_idx),
      .eval_zero(eval_zero), .eval_one(eval_one),
      .chal_valid(chal_valid), .chal_ready(chal_ready), .chal_value(chal_value),
      .done(done), .final_value(final_value)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic run_case(input int c, input bit disturb);
      longint cur [DEPTH];
      longint e0, e1, a, ph;
      int len, half, cyc, exp_lat;
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         load_en = 1'b1; load_addr = LOG_N'(i); load_data = WIDTH'(VEC[c][i]);
         cur[i] = longint'(VEC[c][i]);
      end
      @(negedge clk);
      load_en = 1'b0;
      len = DEPTH; ph = 0;
      start = 1'b1;
      @(posedge clk); cyc = 1;
      @(negedge clk); start = 1'b0;
      for (int k = 1; k <= LOG_N; k++) begin
         half = len / 2;
         e0 = 0; e1 = 0;
         for (int i = 0; i < half; i++) begin
            e0 = (e0 + cur[2*i]) % P;
            e1 = (e1 + cur[2*i+1]) % P;
         end
         while (!round_valid && cyc < 200) begin
            // R7: stray write while busy must not land
            if (disturb && cyc == 2) begin
               load_en = 1'b1; load_addr = '0; load_data = 16'd999;
            end else load_en = 1'b0;
            @(posedge clk); cyc++;
            @(negedge clk);
         end
         load_en = 1'b0;
         exp_lat = (k == 1) ? 1 + half : int'(1 + ph + ph / 2);
         check(cyc == exp_lat, "R6", $sformatf("round %0d latency", k), cyc, exp_lat);
         check(round_idx == 2'(k), "R2", "round index", round_idx, k);
         check(eval_zero == WIDTH'(e0), (k == 1) ? "R2" : "R3", $sformatf("round %0d eval_zero", k), eval_zero, e0);
         check(eval_one == WIDTH'(e1), (k == 1) ? "R2" : "R3", $sformatf("round %0d eval_one", k), eval_one, e1);
         // R4: early challenge while offer stalls
         chal_valid = 1'b1; chal_value = 16'd77;
         if (disturb) start = 1'b1;
         @(posedge clk); @(negedge clk);
         start = 1'b0;
         check(chal_ready == 1'b0, "R4", "chal_ready during stall", chal_ready, 0);
         check(round_valid == 1'b1, "R4", "offer held", round_valid, 1);
         check(eval_zero == WIDTH'(e0) && round_idx == 2'(k), disturb ? "R7" : "R4",
               "offer unchanged after stall", eval_zero, e0);
         round_ready = 1'b1;
         @(posedge clk); @(negedge clk);
         round_ready = 1'b0;
         a = longint'(CHL[c][k-1]);
         chal_value = WIDTH'(a);
         check(chal_ready == 1'b1, "R4", "chal_ready after accept", chal_ready, 1);
         check(round_valid == 1'b0, "R4", "offer dropped after accept", round_valid, 0);
         @(posedge clk); cyc = 1;
         @(negedge clk); chal_valid = 1'b0;
         for (int i = 0; i < half; i++)
            cur[i] = (cur[2*i] + a * ((cur[2*i+1] - cur[2*i] + P) % P)) % P;
         ph = half; len = half;
      end
      while (!done && cyc < 200) begin
         if (round_valid) check(1'b0, "R5", "extra round offered", 1, 0);
         @(posedge clk); cyc++;
         @(negedge clk);
      end
      check(cyc == 2, "R6", "done latency", cyc, 2);
      check(done == 1'b1, "R5", "done flag", done, 1);
      check(final_value == WIDTH'(cur[0]), "R5", "final value", final_value, cur[0]);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); @(negedge clk);
         check(!round_valid && !chal_ready && done, "R5", "quiet after done",
               {round_valid, chal_ready, done}, 1);
      end
   endtask

   initial begin
      #1ms;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!round_valid && !chal_ready && !done, "R1", "outputs in reset",
            {round_valid, chal_ready, done}, 0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check(!round_valid && !chal_ready && !done, "R1", "outputs after reset",
            {round_valid, chal_ready, done}, 0);

      for (int c = 0; c < NCASE; c++) run_case(c, 1'b0);

      // directed: stray load and start while running (R7)
      run_case(3, 1'b1);
      run_case(0, 1'b1);

      // directed: reset in the middle of a run returns to quiet (R1)
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (6) @(negedge clk);
      check(round_valid == 1'b1, "R2", "offer before reset", round_valid, 1);
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check(!round_valid && !chal_ready && !done, "R1", "outputs after mid-run reset",
            {round_valid, chal_ready, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end
endmodule